// File: doc/BRIEF.md
# Direct-Sequence Frame Spreader

This block turns one byte of payload into a 256-chip spread stream. A message source announces a frame with a one-cycle reload strobe and presents the byte in parallel. The block captures the byte and then sends one chip on every clock for 256 clocks. Each chip is one data bit XORed with the chip supplied in that cycle by an external spreading-code generator. Each data bit covers a run of 32 consecutive chips, and the most significant bit goes first.

A small control FSM runs the handshake. It keeps `busy` high until the code generator reports `genReady`. It refuses new frames while one is being sent. It raises `run` so that the generator steps its sequence during chip cycles, and it raises `done` once the last chip has gone out. The generator, carrier modulation and the channel are outside this block.

Top module: `dsss_frame_tx`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`=1, `done`=0, `run`=0, `chipValid`=0 and `chipOut`=0.
- R2: Until `genReady` has been seen high, `busy` stays 1 and `reload` is ignored: no chip cycles start.
- R3: The clock edge that samples `genReady`=1 while the block waits for the generator drops `busy` to 0 after that edge.
- R4: With `busy`=0, a clock edge that samples `reload`=1 captures `dataIn`. Starting in the next cycle, `run`, `chipValid` and `busy` are all 1.
- R5: In chip cycle k (k = 0..255, counted from the first cycle after capture), `chipOut` = `dataIn[7 - k/32]` XOR `chipIn`. The captured byte is used MSB first, and each bit spans 32 chips.
- R6: The frame lasts exactly 256 cycles. In the cycle after chip 255, `chipValid` and `run` are 0, `busy` is 0 and `done` is 1.
- R7: A `reload` while `busy`=1 is ignored. Neither the byte being sent nor the length of the frame changes.
- R8: `done` stays 1 until the next accepted `reload`, and it is 0 from the first chip cycle of that frame.
- R9: Whenever `chipValid`=0, `chipOut`=0. `run` equals `chipValid` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| genReady | input | 1 | Code generator has been seeded and can produce chips |
| chipIn | input | 1 | Current chip from the code generator |
| reload | input | 1 | Source strobe announcing a new byte |
| dataIn | input | 8 | Payload byte, sampled with `reload` |
| run | output | 1 | Asks the code generator to advance one chip per clock |
| chipOut | output | 1 | Spread chip |
| chipValid | output | 1 | High during the 256 chip cycles of a frame |
| busy | output | 1 | Block cannot accept a byte |
| done | output | 1 | Last frame finished; held until the next accepted byte |

## Verification
The bench aims at the bit boundaries every 32 chips. A counter that is off by one there would XOR a neighbouring data bit into the first or last chip of a span. It checks that the frame ends after exactly 256 chips, since a wrong terminal count gives a 255- or 257-chip frame and moves `done` by one cycle. A reload in the middle of a frame, carrying a different byte, exposes a buffer that is recaptured while busy. A reload sent before the generator is ready exposes a controller that starts without a code. Patterns of all ones, all zeros and alternating bits, together with random bytes and random chips, show whether a bit order is reversed or a chip is passed through without its data bit.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;
  typedef struct packed {
    logic loadBuf;   // capture the incoming byte
    logic shiftBit;  // move to the next data bit
    logic active;    // a chip cycle is in progress
  } ctrlStrobesT;
endpackage

// File: rtl/dsss_tx_ctrl.sv
module dsss_tx_ctrl
  import dsss_tx_pkg::*;
#(
  parameter int BITS = 8,
  parameter int CHIPS_PER_BIT = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        genReady,
  input  logic        reload,
  output ctrlStrobesT strobes,
  output logic        run,
  output logic        chipValid,
  output logic        busy,
  output logic        done
);
  localparam int FRAME = BITS * CHIPS_PER_BIT;
  localparam int CNT_W = $clog2(FRAME);

  typedef enum logic [1:0] {ST_NOGEN, ST_IDLE, ST_SEND} stateT;

  stateT             stateQ;
  logic [CNT_W-1:0]  chipCnt;
  logic              doneQ;
  logic              lastChip;
  logic              bitEnd;

  assign lastChip = (chipCnt == CNT_W'(FRAME - 1));
  assign bitEnd   = ((chipCnt % CNT_W'(CHIPS_PER_BIT)) == CNT_W'(CHIPS_PER_BIT - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_NOGEN;
      chipCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      unique case (stateQ)
        ST_NOGEN: if (genReady) stateQ <= ST_IDLE;
        ST_IDLE: begin
          if (reload) begin
            stateQ  <= ST_SEND;
            chipCnt <= '0;
            doneQ   <= 1'b0;
          end
        end
        ST_SEND: begin
          if (lastChip) begin
            stateQ  <= ST_IDLE;
            chipCnt <= '0;
            doneQ   <= 1'b1;
          end else begin
            chipCnt <= chipCnt + 1'b1;
          end
        end
        default: stateQ <= ST_NOGEN;
      endcase
    end
  end

  assign chipValid        = (stateQ == ST_SEND);
  assign run              = chipValid;
  assign busy             = (stateQ != ST_IDLE);
  assign done             = doneQ;
  assign strobes.loadBuf  = (stateQ == ST_IDLE) && reload;
  assign strobes.shiftBit = chipValid && bitEnd;
  assign strobes.active   = chipValid;

  // R3: generator readiness frees the block on the next cycle
  p_ready_frees_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_NOGEN && genReady) |=> !busy);
  // R4: chip cycles only while busy
  p_valid_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    chipValid |-> busy);
  // R6: done and busy never together
  p_done_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R6: done rises only right after a chip cycle
  p_done_after_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(chipValid));
  // R7: a frame in progress keeps going until its last chip
  p_no_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (chipValid && !lastChip) |=> chipValid);
endmodule

// File: rtl/dsss_tx_datapath.sv
module dsss_tx_datapath
  import dsss_tx_pkg::*;
#(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobesT     strobes,
  input  logic [BITS-1:0] dataIn,
  input  logic            chipIn,
  output logic            chipOut
);
  logic [BITS-1:0] bufQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufQ <= '0;
    end else if (strobes.loadBuf) begin
      bufQ <= dataIn;
    end else if (strobes.shiftBit) begin
      bufQ <= {bufQ[BITS-2:0], 1'b0};
    end
  end

  assign chipOut = strobes.active & (bufQ[BITS-1] ^ chipIn);

  // R9: quiet line outside chip cycles
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.active |-> !chipOut);
  // R7: buffer only changes through capture or bit shift
  p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadBuf && !strobes.shiftBit) |=> $stable(bufQ));
endmodule

// File: rtl/dsss_frame_tx.sv
module dsss_frame_tx
  import dsss_tx_pkg::*;
#(
  parameter int BITS = 8,
  parameter int CHIPS_PER_BIT = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            genReady,
  input  logic            chipIn,
  input  logic            reload,
  input  logic [BITS-1:0] dataIn,
  output logic            run,
  output logic            chipOut,
  output logic            chipValid,
  output logic            busy,
  output logic            done
);
  ctrlStrobesT strobes;

  dsss_tx_ctrl #(.BITS(BITS), .CHIPS_PER_BIT(CHIPS_PER_BIT)) uCtrl (
    .clk(clk), .rstN(rstN), .genReady(genReady), .reload(reload),
    .strobes(strobes), .run(run), .chipValid(chipValid),
    .busy(busy), .done(done)
  );

  dsss_tx_datapath #(.BITS(BITS)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dataIn(dataIn),
    .chipIn(chipIn), .chipOut(chipOut)
  );

  // R9: run mirrors chipValid
  always_comb begin
    if (rstN) p_run_valid_r9: assert (run == chipValid);
  end
endmodule

// File: tb/dsss_frame_tx_test.sv
module dsss_frame_tx_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic genReady = 1'b0;
  logic chipIn = 1'b0;
  logic reload = 1'b0;
  logic [7:0] dataIn = 8'h00;
  logic run, chipOut, chipValid, busy, done;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dsss_frame_tx uut (
    .clk(clk), .rstN(rstN), .genReady(genReady), .chipIn(chipIn),
    .reload(reload), .dataIn(dataIn), .run(run), .chipOut(chipOut),
    .chipValid(chipValid), .busy(busy), .done(done)
  );

  function automatic logic expChip(logic [7:0] d, int k, logic c);
    return d[7 - k / 32] ^ c;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idleCheck(string tag);
    chk(busy == 1'b0 && chipValid == 1'b0 && run == 1'b0, {tag, " idle"},
        {busy, chipValid, run}, 0);
    chk(chipOut == 1'b0, "R9 chipOut quiet", chipOut, 0);
  endtask

  // Called at a negedge while idle; returns at the negedge after the frame.
  task automatic sendFrame(logic [7:0] d, bit midReload);
    int badChips;
    reload = 1'b1;
    dataIn = d;
    @(negedge clk);
    reload = 1'b0;
    dataIn = 8'($urandom);
    chk(done == 1'b0, "R8 done cleared at frame start", done, 0);
    badChips = 0;
    for (int k = 0; k < 256; k++) begin
      chipIn = 1'($urandom);
      #1;
      if (!(chipValid && run && busy)) begin
        chk(0, "R4 chip cycle flags", {chipValid, run, busy}, 7);
      end
      if (chipOut !== expChip(d, k, chipIn)) begin
        badChips++;
        chk(0, "R5 chip value", chipOut, expChip(d, k, chipIn));
      end
      if (midReload && k == 100) begin
        reload = 1'b1;
        dataIn = ~d;
      end else begin
        reload = 1'b0;
      end
      @(negedge clk);
    end
    reload = 1'b0;
    chk(badChips == 0, "R5 whole frame spread", badChips, 0);
    chk(chipValid == 1'b0 && run == 1'b0, "R6 frame ends after 256 chips",
        chipValid, 0);
    chk(busy == 1'b0 && done == 1'b1, "R6 done raised", {busy, done}, 1);
  endtask

  initial begin
    void'($urandom(32'd7041));
    #1;
    chk(busy && !done && !run && !chipValid && !chipOut, "R1 reset state",
        {busy, done, run, chipValid, chipOut}, 16);
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy && !done && !run && !chipValid, "R1 after reset",
        {busy, done, run, chipValid}, 8);
    // R2: reload before generator ready
    reload = 1'b1;
    dataIn = 8'h5A;
    repeat (3) @(negedge clk);
    reload = 1'b0;
    chk(busy == 1'b1 && chipValid == 1'b0, "R2 reload ignored before ready",
        {busy, chipValid}, 2);
    // R3
    genReady = 1'b1;
    chk(busy == 1'b1, "R3 busy before edge", busy, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R3 busy drops after ready", busy, 0);
    chk(done == 1'b0, "R3 done still low", done, 0);
    idleCheck("R4 before first reload");
    // directed patterns
    sendFrame(8'hFF, 0);
    repeat (3) begin
      @(negedge clk);
      chk(done == 1'b1, "R8 done held while idle", done, 1);
      idleCheck("R9 between frames");
    end
    sendFrame(8'h00, 0);
    sendFrame(8'hA5, 1);  // R7 mid-frame reload with ~data
    @(negedge clk);
    idleCheck("R7 no restart after ignored reload");
    sendFrame(8'h01, 0);
    sendFrame(8'h80, 1);
    // random frames, some back to back
    for (int f = 0; f < 6; f++) begin
      sendFrame(8'($urandom), 1'($urandom));
      if (f[0]) @(negedge clk);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !finished) begin
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end
endmodule